// File: doc/BRIEF.md
# Video Memory Fetch and Serializer

This block sits between a display timebase and a shared single-port video memory. It watches the horizontal and vertical position counters and computes the address of the next display word. It reads one byte for every eight pixel clocks, captures that byte in a parallel-load shift register, and sends the pixels out one bit per pixel clock, most significant bit first. The read is issued in the last phase of the previous group, so the first visible pixel of every line already has its data.

A host can also use the same memory bus, but only while the frame sync pulse is active and the timebase is on a blanking line. During that time the memory address, write data and write enable come from the host port. Display fetches never happen during that window, so a host write never disturbs the picture while it is being drawn. A request made outside the window stays pending until the next frame sync.

Top module: `vid_fetch_ser`

## Requirements
- R1: On a fetch cycle, `mem_addr_o` equals `nv*(H_VIS/8) + nh/8`, where (nh, nv) is the position that follows the current one. The address goes back to 0 for the first word of each frame.
- R2: A fetched byte drives the pixels of its 8-pixel group starting with bit 7. The pixel at column h shows bit `7 - h%8` of word `v*(H_VIS/8) + h/8`.
- R3: `pix_o` is 0 whenever `hcnt_i >= H_VIS` or `vcnt_i >= V_VIS`.
- R4: A fetch happens only when `hcnt_i[2:0] == 7` and the next position is visible, so two fetches are never on adjacent cycles.
- R5: `host_grant_o` is 1 in a cycle only if `host_req_i` and `vsync_i` were both 1 in that cycle and in the cycle before, with `V_VIS <= vcnt_i < V_TOTAL-1` in both cycles. It drops in the same cycle that `vsync_i` falls.
- R6: A request made outside the frame sync window gets no grant. If the request is held, it is granted one cycle after the window opens.
- R7: While granted, `mem_addr_o`, `mem_wdata_o` and `mem_we_o` follow `host_addr_i`, `host_wdata_i` and `host_we_i`. When not granted, `mem_we_o` is 0.
- R8: While `rst_ni` is low, `pix_o`, `host_grant_o` and `mem_we_o` are 0 and `mem_addr_o` is 0.
- R9: The first pixel of every visible line (column 0) already shows bit 7 of that line's first word.
- R10: Data written by the host during frame sync appears in the pixels of the following frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hcnt_i | input | H_W | Horizontal position from the timebase |
| vcnt_i | input | V_W | Vertical position from the timebase |
| vsync_i | input | 1 | Frame sync pulse, active high |
| host_req_i | input | 1 | Host bus request (level) |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host memory address |
| host_wdata_i | input | DATA_W | Host write data |
| mem_rdata_i | input | DATA_W | Memory read data (combinational read) |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write enable |
| pix_o | output | 1 | Serial pixel output |
| host_grant_o | output | 1 | Host owns the memory bus |

## Verification
Each state register shows its errors at the ports quickly:
- A wrong word counter produces a bad address at the very next fetch. It also appears in `pix_o` one cycle later and stays wrong for the rest of the frame.
- A shift register that is loaded or shifted wrongly breaks the bit order within the current 8-pixel group.
- A wrong grant register shows on `host_grant_o` and `mem_we_o` in the cycle right after the request or sync edge.

The bench has a model that compares these outputs on every clock. It also checks the host-written data in later frames, which catches a write that lands at the wrong address.

// File: rtl/vfs_pkg.sv
package vfs_pkg;
  typedef enum logic {
    OWN_DISPLAY = 1'b0,
    OWN_HOST    = 1'b1
  } bus_owner_e;
endpackage

// File: rtl/vfs_pos_dec.sv
module vfs_pos_dec #(
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_VIS   = 480,
  parameter int unsigned V_TOTAL = 525,
  parameter int unsigned H_W     = 10,
  parameter int unsigned V_W     = 10,
  parameter int unsigned PH_W    = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] hcnt_i,
  input  logic [V_W-1:0] vcnt_i,
  output logic           vis_o,
  output logic           fetch_o,
  output logic           frame_first_o,
  output logic           blank_line_o,
  output logic           host_window_o
);
  localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
  localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

  logic           h_wrap;
  logic [H_W-1:0] nh;
  logic [V_W-1:0] nv;
  logic           next_vis;

  always_comb begin
    h_wrap = (hcnt_i == H_LAST);
    nh     = h_wrap ? '0 : hcnt_i + H_W'(1);
    if (!h_wrap)                nv = vcnt_i;
    else if (vcnt_i == V_LAST)  nv = '0;
    else                        nv = vcnt_i + V_W'(1);
    next_vis = (32'(nh) < H_VIS) && (32'(nv) < V_VIS);
  end

  assign vis_o         = (32'(hcnt_i) < H_VIS) && (32'(vcnt_i) < V_VIS);
  assign fetch_o       = (&hcnt_i[PH_W-1:0]) && next_vis;
  assign frame_first_o = fetch_o && (nh == '0) && (nv == '0);
  assign blank_line_o  = (32'(vcnt_i) >= V_VIS);
  assign host_window_o = blank_line_o && (vcnt_i != V_LAST);

  p_fetch_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_o |=> !fetch_o);
endmodule

// File: rtl/vfs_addr_gen.sv
module vfs_addr_gen #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              clear_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (fetch_i) addr_q <= addr_q + ADDR_W'(1);
    else if (clear_i) addr_q <= '0;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/vfs_shifter.sv
module vfs_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= din_i;
    else             sh_q <= {sh_q[DATA_W-2:0], 1'b0};
  end

  assign msb_o = sh_q[DATA_W-1];

  p_load_msb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> msb_o == $past(din_i[DATA_W-1]));
endmodule

// File: rtl/vfs_host_arb.sv
module vfs_host_arb
  import vfs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       vsync_i,
  input  logic       window_i,
  output bus_owner_e owner_o
);
  logic ok_now;
  logic ok_q;

  assign ok_now = req_i && vsync_i && window_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= ok_now;
  end

  // registered qualify, combinational release on sync end
  assign owner_o = (ok_q && ok_now) ? OWN_HOST : OWN_DISPLAY;

  p_grant_after_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_o == OWN_HOST) |-> $past(req_i) && $past(vsync_i));
endmodule

// File: rtl/vid_fetch_ser.sv
module vid_fetch_ser
  import vfs_pkg::*;
#(
  parameter int unsigned H_VIS   = 640,
  parameter int unsigned H_TOTAL = 800,
  parameter int unsigned V_VIS   = 480,
  parameter int unsigned V_TOTAL = 525,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned H_W     = $clog2(H_TOTAL),
  parameter int unsigned V_W     = $clog2(V_TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [H_W-1:0]    hcnt_i,
  input  logic [V_W-1:0]    vcnt_i,
  input  logic              vsync_i,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              pix_o,
  output logic              host_grant_o
);
  localparam int unsigned PH_W = $clog2(DATA_W);

  logic              vis, fetch, frame_first, blank_line, host_window;
  logic [ADDR_W-1:0] disp_addr;
  logic              sh_msb;
  bus_owner_e        owner;

  vfs_pos_dec #(
    .H_VIS(H_VIS), .H_TOTAL(H_TOTAL), .V_VIS(V_VIS), .V_TOTAL(V_TOTAL),
    .H_W(H_W), .V_W(V_W), .PH_W(PH_W)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .hcnt_i(hcnt_i), .vcnt_i(vcnt_i),
    .vis_o(vis), .fetch_o(fetch), .frame_first_o(frame_first),
    .blank_line_o(blank_line), .host_window_o(host_window)
  );

  vfs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i(clk_i), .rst_ni(rst_ni), .fetch_i(fetch),
    .clear_i(blank_line && !fetch), .addr_o(disp_addr)
  );

  vfs_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(fetch),
    .din_i(mem_rdata_i), .msb_o(sh_msb)
  );

  vfs_host_arb u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(host_req_i), .vsync_i(vsync_i),
    .window_i(host_window), .owner_o(owner)
  );

  assign host_grant_o = (owner == OWN_HOST);
  assign mem_addr_o   = host_grant_o ? host_addr_i : disp_addr;
  assign mem_wdata_o  = host_wdata_i;
  assign mem_we_o     = host_grant_o && host_we_i;
  assign pix_o        = vis && sh_msb;

  p_first_word_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_first |-> mem_addr_o == '0);
  p_grant_no_fetch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_grant_o |-> !fetch);
  p_grant_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_grant_o |-> (32'(vcnt_i) >= V_VIS) && vsync_i);
endmodule

// File: tb/vid_fetch_ser_test.sv
module vid_fetch_ser_test;
  localparam int H_VIS = 32, H_TOT = 48, V_VIS = 4, V_TOT = 8;
  localparam int AW = 8, DW = 8, HW = 6, VW = 3;
  localparam int WPL = H_VIS / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic vsync, req, we;
  logic [AW-1:0] haddr, maddr;
  logic [DW-1:0] hwdata, mwdata, rdata;
  logic mwe, pix, grant;
  logic [DW-1:0] mem [256];

  int checks = 0, fails = 0;
  int h = 0, v = V_VIS, f = 0;
  bit prev_ok = 1'b0;

  always #2 clk = ~clk;

  vid_fetch_ser #(
    .H_VIS(H_VIS), .H_TOTAL(H_TOT), .V_VIS(V_VIS), .V_TOTAL(V_TOT),
    .ADDR_W(AW), .DATA_W(DW), .H_W(HW), .V_W(VW)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .hcnt_i(hcnt), .vcnt_i(vcnt), .vsync_i(vsync),
    .host_req_i(req), .host_we_i(we), .host_addr_i(haddr), .host_wdata_i(hwdata),
    .mem_rdata_i(rdata), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_we_o(mwe), .pix_o(pix), .host_grant_o(grant)
  );

  assign rdata = mem[maddr];

  always @(posedge clk) if (mwe) mem[maddr] <= mwdata;

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s h=%0d v=%0d f=%0d actual=%0d expected=%0d", req_tag, h, v, f, act, exp);
    end
  endtask

  task automatic drive();
    hcnt   = HW'(h);
    vcnt   = VW'(v);
    vsync  = (v == 5) || (v == 6);
    case (f)
      1: req = (v >= 1);                       // pending before sync (R6)
      2: req = (v == 6) && (h >= 10);          // raised inside sync
      3: req = (v == 5) && (h < 20);           // dropped inside sync
      default: req = 1'b0;
    endcase
    we     = h[0];
    haddr  = AW'(h % 16);
    hwdata = DW'((h * 7) ^ (f * 51) ^ 8'h5A);
  endtask

  task automatic check_cycle();
    bit vis, ok_now, exp_g, fetch_exp;
    int nh, nv, word;
    vis    = (h < H_VIS) && (v < V_VIS);
    ok_now = req && vsync && (v >= V_VIS) && (v != V_TOT - 1);
    exp_g  = prev_ok && ok_now;
    // R5 R6: grant one cycle after qualified request, drops with sync
    chk("R5/R6 grant", int'(grant), int'(exp_g));
    // R7: write enable only under grant
    chk("R7 we", int'(mwe), int'(exp_g && we));
    if (exp_g) begin
      chk("R7 addr", int'(maddr), int'(haddr));
      chk("R7 wdata", int'(mwdata), int'(hwdata));
    end
    nh = (h == H_TOT - 1) ? 0 : h + 1;
    nv = (h == H_TOT - 1) ? ((v == V_TOT - 1) ? 0 : v + 1) : v;
    fetch_exp = (h % 8 == 7) && (nh < H_VIS) && (nv < V_VIS);
    // R1 R4: fetch address on phase-7 cycles ahead of visible group
    if (fetch_exp) chk("R1/R4 fetch addr", int'(maddr), nv * WPL + nh / 8);
    if (vis) begin
      word = v * WPL + h / 8;
      // R2 R9 R10: MSB first from current memory (host writes included)
      if (h == 0) chk("R9 first pixel", int'(pix), int'(mem[word][7]));
      else        chk("R2/R10 pixel", int'(pix), int'(mem[word][7 - h % 8]));
    end else begin
      chk("R3 blank", int'(pix), 0);
    end
    prev_ok = ok_now;
  endtask

  task automatic advance();
    if (h == H_TOT - 1) begin
      h = 0;
      if (v == V_TOT - 1) begin v = 0; f++; end
      else v++;
    end else h++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = DW'(i * 29 + 3);
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R8: reset state
    chk("R8 grant", int'(grant), 0);
    chk("R8 we", int'(mwe), 0);
    chk("R8 pix", int'(pix), 0);
    chk("R8 addr", int'(maddr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    forever begin
      drive();
      #1;
      check_cycle();
      if (f == 5) break;
      @(negedge clk);
      advance();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule